// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block holds a bank of address windows that software programs through a 32-bit register port. Each window names a destination device by a 4-bit target and an 8-bit attribute, covers a span of the 36-bit physical address space in 64 KB steps, and may carry a translation base. A combinational lookup port takes one 36-bit address and, in the same cycle, reports whether a window claims it, which window, the destination pair, and the address to forward.

The register map is deliberately uneven. The first eight windows each have four words: control, base, translation low and translation high. A 16-byte gap follows. The remaining twelve windows each have only a control word and a base word, so they cannot translate and forward the incoming address unchanged. The block does not choose windows, reject overlaps or resolve device names. It decodes with whatever is programmed at that moment.

Top module: `addr_window_decoder`

## Requirements
- R1: After a synchronous reset every register reads zero, every window is disabled and every lookup misses.
- R2: A control word stores enable in bit 0, target in bits 7:4, attribute in bits 15:8 and the window length minus one, counted in 64 KB units, in bits 31:16. Bits 3:1 are not stored and read back as zero.
- R3: A base word stores address bits 31:16 in its bits 31:16 and address bits 35:32 in its bits 3:0. Every other bit reads zero. A translation-low word keeps bits 31:16 only, and a translation-high word keeps bits 3:0 only.
- R4: A window claims an address only when it is enabled and base <= address < base + (length field + 1) * 65536.
- R5: When several enabled windows claim an address, the output reports the lowest-numbered one.
- R6: When no window claims the address, hit is 0 and window index, target, attribute and translated address are all 0.
- R7: A hit in windows 0 to 7 yields the translated address ({translation-high[3:0], translation-low[31:16], 16'h0} + (address − window base)) mod 2^36.
- R8: A hit in windows 8 to 19 yields the incoming address unchanged.
- R9: Window w < 8 has its control, base, translation-low and translation-high words at byte offsets 16w, 16w+4, 16w+8 and 16w+12. Window w >= 8 has its control at 0x90 + 8(w−8) and its base at 0x94 + 8(w−8).
- R10: Offsets 0x80 to 0x8F and offsets 0xF0 and above read zero. Writes to them change no register and no lookup result.
- R11: Writing zero to a window's control word disables it for lookups from the next clock onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 8 | Byte offset of the register to access (bits 1:0 ignored) |
| reg_we | input | 1 | Write strobe, captured at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| lk_addr | input | 36 | Address to decode |
| lk_hit | output | 1 | A window claims lk_addr |
| lk_win | output | 5 | Index of the claiming window |
| lk_target | output | 4 | Target of the claiming window |
| lk_attr | output | 8 | Attribute of the claiming window |
| lk_xaddr | output | 36 | Translated or passed-through address |

## Verification
The assertions assume reg_addr and reg_we are stable at each sampling edge and are known once reset is released. They also assume the write-readback property on window 0 only counts when the bench holds that offset into the next cycle. The random stimulus writes only word-aligned offsets. It keeps window bases in a narrow region and lengths small, so overlaps, priority contests and both edges of a window come up often. Lookup addresses are drawn near programmed bases, from just below a window to past its end, so that both hits and misses are exercised.

// File: rtl/addr_window_decoder.sv
`timescale 1ns/1ps
module addr_window_decoder #(
  parameter int NUM_WIN    = 20,
  parameter int NUM_REMAP  = 8,
  parameter int HOLE_BYTES = 16,
  parameter int HI_W       = 4,
  localparam int ADDR_W     = 32 + HI_W,
  localparam int WIN_W      = $clog2(NUM_WIN),
  localparam int LONG_SPAN  = NUM_REMAP * 16,
  localparam int SHORT_BASE = LONG_SPAN + HOLE_BYTES,
  localparam int MAP_END    = SHORT_BASE + (NUM_WIN - NUM_REMAP) * 8,
  localparam int OFF_W      = $clog2(MAP_END + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OFF_W-1:0]  reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [WIN_W-1:0]  lk_win,
  output logic [3:0]        lk_target,
  output logic [7:0]        lk_attr,
  output logic [ADDR_W-1:0] lk_xaddr
);
  localparam logic [OFF_W-1:0] A_LONG_END = OFF_W'(LONG_SPAN);
  localparam logic [OFF_W-1:0] A_SHORT    = OFF_W'(SHORT_BASE);
  localparam logic [OFF_W-1:0] A_END      = OFF_W'(MAP_END);

  logic [NUM_WIN-1:0] w_en;
  logic [3:0]         w_tgt  [NUM_WIN];
  logic [7:0]         w_attr [NUM_WIN];
  logic [15:0]        w_szm1 [NUM_WIN];
  logic [15:0]        w_blo  [NUM_WIN];
  logic [HI_W-1:0]    w_bhi  [NUM_WIN];
  logic [15:0]        r_lo   [NUM_REMAP];
  logic [HI_W-1:0]    r_hi   [NUM_REMAP];

  logic               dec_ok;
  logic [WIN_W-1:0]   dec_win;
  logic [1:0]         dec_reg;
  logic [OFF_W-1:0]   rel;

  assign rel = reg_addr - A_SHORT;

  always_comb begin
    dec_ok  = 1'b0;
    dec_win = '0;
    dec_reg = 2'd0;
    if (reg_addr < A_LONG_END) begin
      dec_ok  = 1'b1;
      dec_win = WIN_W'(reg_addr >> 4);
      dec_reg = reg_addr[3:2];
    end else if (reg_addr >= A_SHORT && reg_addr < A_END) begin
      dec_ok  = 1'b1;
      dec_win = WIN_W'(NUM_REMAP) + WIN_W'(rel >> 3);
      dec_reg = {1'b0, rel[2]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      w_en <= '0;
      for (int w = 0; w < NUM_WIN; w++) begin
        w_tgt[w]  <= '0;
        w_attr[w] <= '0;
        w_szm1[w] <= '0;
        w_blo[w]  <= '0;
        w_bhi[w]  <= '0;
      end
      for (int w = 0; w < NUM_REMAP; w++) begin
        r_lo[w] <= '0;
        r_hi[w] <= '0;
      end
    end else if (reg_we && dec_ok) begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (dec_win == WIN_W'(w)) begin
          if (dec_reg == 2'd0) begin
            w_en[w]   <= reg_wdata[0];
            w_tgt[w]  <= reg_wdata[7:4];
            w_attr[w] <= reg_wdata[15:8];
            w_szm1[w] <= reg_wdata[31:16];
          end else if (dec_reg == 2'd1) begin
            w_blo[w] <= reg_wdata[31:16];
            w_bhi[w] <= reg_wdata[HI_W-1:0];
          end
        end
      end
      for (int w = 0; w < NUM_REMAP; w++) begin
        if (dec_win == WIN_W'(w)) begin
          if (dec_reg == 2'd2)      r_lo[w] <= reg_wdata[31:16];
          else if (dec_reg == 2'd3) r_hi[w] <= reg_wdata[HI_W-1:0];
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (dec_ok) begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (dec_win == WIN_W'(w)) begin
          case (dec_reg)
            2'd0:    reg_rdata = {w_szm1[w], w_attr[w], w_tgt[w], 3'b000, w_en[w]};
            2'd1:    reg_rdata = {w_blo[w], {(16-HI_W){1'b0}}, w_bhi[w]};
            default: ;
          endcase
        end
      end
      for (int w = 0; w < NUM_REMAP; w++) begin
        if (dec_win == WIN_W'(w)) begin
          case (dec_reg)
            2'd2:    reg_rdata = {r_lo[w], 16'h0000};
            2'd3:    reg_rdata = {{(32-HI_W){1'b0}}, r_hi[w]};
            default: ;
          endcase
        end
      end
    end
  end

  logic [NUM_WIN-1:0] hit_v;
  logic [ADDR_W-1:0]  xa_v [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [ADDR_W-1:0] base_a;
    logic [ADDR_W:0]   diff;
    logic [ADDR_W-1:0] lim;
    assign base_a   = {w_bhi[w], w_blo[w], 16'h0000};
    assign diff     = {1'b0, lk_addr} - {1'b0, base_a};
    assign lim      = {{HI_W{1'b0}}, w_szm1[w], 16'hFFFF};
    assign hit_v[w] = w_en[w] && !diff[ADDR_W] && (diff[ADDR_W-1:0] <= lim);
    if (w < NUM_REMAP) begin : g_rmp
      assign xa_v[w] = {r_hi[w], r_lo[w], 16'h0000} + diff[ADDR_W-1:0];
    end else begin : g_pass
      assign xa_v[w] = lk_addr;
    end
  end

  always_comb begin
    lk_hit    = 1'b0;
    lk_win    = '0;
    lk_target = '0;
    lk_attr   = '0;
    lk_xaddr  = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit_v[w]) begin
        lk_hit    = 1'b1;
        lk_win    = WIN_W'(w);
        lk_target = w_tgt[w];
        lk_attr   = w_attr[w];
        lk_xaddr  = xa_v[w];
      end
    end
  end
endmodule

// File: rtl/addr_window_decoder_chk.sv
`timescale 1ns/1ps
module addr_window_decoder_chk #(
  parameter int NUM_WIN    = 20,
  parameter int NUM_REMAP  = 8,
  parameter int LONG_SPAN  = 128,
  parameter int SHORT_BASE = 144,
  parameter int MAP_END    = 240,
  parameter int OFF_W      = 8,
  parameter int WIN_W      = 5,
  parameter int ADDR_W     = 36
) (
  input logic              clk,
  input logic              rst,
  input logic [OFF_W-1:0]  reg_addr,
  input logic              reg_we,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              lk_hit,
  input logic [WIN_W-1:0]  lk_win,
  input logic [3:0]        lk_target,
  input logic [7:0]        lk_attr,
  input logic [ADDR_W-1:0] lk_xaddr
);
  localparam logic [OFF_W-1:0] C_HOLE_LO = OFF_W'(LONG_SPAN);
  localparam logic [OFF_W-1:0] C_HOLE_HI = OFF_W'(SHORT_BASE);
  localparam logic [OFF_W-1:0] C_END     = OFF_W'(MAP_END);
  localparam logic [WIN_W-1:0] C_NWIN    = WIN_W'(NUM_WIN);
  localparam logic [WIN_W-1:0] C_NRMP    = WIN_W'(NUM_REMAP);

  a_r1_reset_miss: assert property (@(posedge clk) $fell(rst) |-> !lk_hit);

  a_r2_ctrl_readback: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == '0) |=>
      (reg_addr != '0 || reg_rdata == ($past(reg_wdata) & 32'hFFFF_FFF1)));

  a_r5_win_range: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_win < C_NWIN);

  a_r6_miss_zero: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_win == '0 && lk_target == '0 && lk_attr == '0 && lk_xaddr == '0));

  a_r8_passthru: assert property (@(posedge clk) disable iff (rst)
    (lk_hit && lk_win >= C_NRMP) |-> lk_xaddr == lk_addr);

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    ((reg_addr >= C_HOLE_LO && reg_addr < C_HOLE_HI) || reg_addr >= C_END) |-> reg_rdata == '0);

  a_r11_disable: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == '0 && reg_wdata == '0) |=> !(lk_hit && lk_win == '0));
endmodule

bind addr_window_decoder addr_window_decoder_chk #(
  .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .LONG_SPAN(LONG_SPAN),
  .SHORT_BASE(SHORT_BASE), .MAP_END(MAP_END), .OFF_W(OFF_W),
  .WIN_W(WIN_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
  .lk_hit(lk_hit), .lk_win(lk_win), .lk_target(lk_target),
  .lk_attr(lk_attr), .lk_xaddr(lk_xaddr)
);

// File: tb/tb_addr_window_decoder.sv
`timescale 1ns/1ps
module tb_addr_window_decoder;
  localparam int NW = 20;
  localparam int NR = 8;
  localparam longint unsigned AMASK = 64'hF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [35:0] lk_addr = '0;
  logic        lk_hit;
  logic [4:0]  lk_win;
  logic [3:0]  lk_target;
  logic [7:0]  lk_attr;
  logic [35:0] lk_xaddr;

  addr_window_decoder dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_win(lk_win), .lk_target(lk_target),
    .lk_attr(lk_attr), .lk_xaddr(lk_xaddr)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] m_ctrl [NW];
  logic [31:0] m_base [NW];
  logic [31:0] m_rlo  [NR];
  logic [31:0] m_rhi  [NR];

  function automatic void m_locate(input int a, output int w, output int r);
    if (a < 'h80) begin w = a / 16; r = (a % 16) / 4; end
    else if (a >= 'h90 && a < 'hF0) begin w = 8 + (a - 'h90) / 8; r = ((a - 'h90) % 8) / 4; end
    else begin w = -1; r = -1; end
  endfunction

  function automatic void m_write(input int a, input logic [31:0] d);
    int w, r;
    m_locate(a, w, r);
    case (r)
      0: m_ctrl[w] = d & 32'hFFFF_FFF1;
      1: m_base[w] = d & 32'hFFFF_000F;
      2: m_rlo[w]  = d & 32'hFFFF_0000;
      3: m_rhi[w]  = d & 32'h0000_000F;
      default: ;
    endcase
  endfunction

  function automatic logic [31:0] m_read(input int a);
    int w, r;
    m_locate(a, w, r);
    case (r)
      0: return m_ctrl[w];
      1: return m_base[w];
      2: return m_rlo[w];
      3: return m_rhi[w];
      default: return 32'h0;
    endcase
  endfunction

  function automatic longint unsigned m_wbase(input int w);
    return (longint'(m_base[w] & 32'hF) << 32) | longint'(m_base[w] & 32'hFFFF_0000);
  endfunction

  function automatic longint unsigned m_wsize(input int w);
    return (longint'(m_ctrl[w] >> 16) + 1) << 16;
  endfunction

  function automatic void m_lookup(input longint unsigned a, output longint unsigned key,
                                   output longint unsigned xa);
    key = 0;
    xa  = 0;
    for (int w = 0; w < NW; w++) begin
      longint unsigned b, s;
      b = m_wbase(w);
      s = m_wsize(w);
      if (m_ctrl[w][0] && a >= b && a < b + s) begin
        key = (64'd1 << 17) | (longint'(w) << 12) | (longint'(m_ctrl[w][7:4]) << 8)
              | longint'(m_ctrl[w][15:8]);
        if (w < NR)
          xa = ((((longint'(m_rhi[w] & 32'hF)) << 32) | longint'(m_rlo[w])) + (a - b)) & AMASK;
        else
          xa = a;
        return;
      end
    end
  endfunction

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_addr  = 8'(a);
    reg_wdata = d;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    m_write(a, d);
  endtask

  task automatic rd(input int a, input string tag);
    @(negedge clk);
    reg_addr = 8'(a);
    #1;
    chk(tag, longint'(reg_rdata), longint'(m_read(a)));
  endtask

  task automatic lk(input longint unsigned a, input string tag);
    longint unsigned ek, ex, ak;
    @(negedge clk);
    lk_addr = 36'(a);
    #1;
    m_lookup(a, ek, ex);
    ak = (longint'(lk_hit) << 17) | (longint'(lk_win) << 12) | (longint'(lk_target) << 8)
         | longint'(lk_attr);
    chk({tag, " match"}, ak, ek);
    chk({tag, " xaddr"}, longint'(lk_xaddr), ex);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < NW; w++) begin m_ctrl[w] = '0; m_base[w] = '0; end
    for (int w = 0; w < NR; w++) begin m_rlo[w] = '0; m_rhi[w] = '0; end
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd('h00, "R1 ctrl0");
    rd('h04, "R1 base0");
    rd('h08, "R1 rlo0");
    rd('h94, "R1 base8");
    lk(36'h0_0000_0000, "R1 lookup zero");

    // R2 / R3 field packing, R9 long slot layout
    wr('h00, 32'h000F_A53F);
    rd('h00, "R2 ctrl0 fields");
    wr('h04, 32'h1230_FFF2);
    rd('h04, "R3 base0 fields");
    wr('h08, 32'h4000_1234);
    rd('h08, "R3 rlo0 fields");
    wr('h0C, 32'hFFFF_FFF5);
    rd('h0C, "R9 rhi0 offset");

    // R4 / R7 boundaries of window 0 (base 0x2_1230_0000, 1 MB)
    lk(36'h2_1230_0000, "R7 first byte");
    lk(36'h2_123F_FFFF, "R4 last byte");
    lk(36'h2_1240_0000, "R4 R6 one past end");
    lk(36'h2_122F_FFFF, "R4 R6 one below base");

    // R8 / R9 short slots
    wr('hA0, 32'h0003_4471);
    wr('hA4, 32'h8000_0000);
    rd('hA0, "R9 win10 ctrl");
    lk(36'h0_8002_0000, "R8 win10 passthru");
    wr('hE8, 32'h0000_1281);
    wr('hEC, 32'h9000_0001);
    rd('hEC, "R9 win19 base");
    lk(36'h1_9000_0010, "R8 win19 hit");

    // R5 priority: window 3 overlaps window 10
    wr('h30, 32'h0000_0291);
    wr('h34, 32'h8000_0000);
    lk(36'h0_8000_1000, "R5 lower index wins");
    lk(36'h0_8001_0000, "R5 only win10");

    // R10 unmapped offsets
    wr('h80, 32'hFFFF_FFFF);
    wr('h8C, 32'hFFFF_FFFF);
    wr('hF0, 32'hFFFF_FFFF);
    wr('hFC, 32'hFFFF_FFFF);
    rd('h80, "R10 hole read");
    rd('h8C, "R10 hole end read");
    rd('hF4, "R10 past end read");
    for (int a = 0; a < 256; a += 4) rd(a, "R10 map intact");
    lk(36'h2_1230_0040, "R10 lookup intact");

    // R11 disable by zero
    wr('h30, 32'h0);
    wr('h34, 32'h0);
    lk(36'h0_8000_1000, "R11 win3 disabled");
    rd('h30, "R11 ctrl zero");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      op = int'($urandom % 10);
      if (op < 4) begin
        int w, r, a;
        logic [31:0] d;
        w = int'($urandom % NW);
        r = (w < NR) ? int'($urandom % 4) : int'($urandom % 2);
        a = (w < NR) ? (w * 16 + r * 4) : ('h90 + (w - 8) * 8 + r * 4);
        case (r)
          0: d = {16'($urandom % 8), 8'($urandom), 4'($urandom), 3'($urandom),
                  1'(($urandom % 4) != 0)};
          1: d = {4'h0, 12'($urandom % 64) << 2, 12'($urandom), 4'($urandom % 2)};
          default: d = $urandom;
        endcase
        wr(a, d);
      end else if (op < 9) begin
        int w;
        longint unsigned a;
        w = int'($urandom % NW);
        a = m_wbase(w) + longint'($urandom % 32'h000A_0000) - 64'h0000_1000;
        lk(a & AMASK, "R4 R5 R7 R8 random lookup");
      end else begin
        rd(int'($urandom % 64) * 4, "R2 R3 R9 R10 random read");
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule